// File: doc/BRIEF.md
# Mode-selectable serial baud clock generator

This block produces the bit-rate timing for a serial port that runs either asynchronously or with a shared clock. Software loads a 16-bit divisor one byte at a time, through a high-byte strobe and a low-byte strobe. Three level inputs pick the operating point:

- divisor width: 8-bit or 16-bit;
- a fast-rate select;
- synchronous operation.

From these the block divides the system clock by 64, 16 or 4 times (divisor + 1).

Two cascaded counters do the division. A 6-bit prescaler counts 64, 16 or 4 clocks and pulses `sample_en` once per round; shift or oversampling logic uses that pulse as its clock enable. The divisor counter advances on each `sample_en` and wraps after divisor + 1 steps. `baud_tick` is high for exactly one clock on the `sample_en` that completes the divisor round.

A write to either divisor byte restarts both counters in the same cycle, so a new rate starts a full fresh period at once. A change on any mode input does the same. There is no data stream at this block's edge, so every pin is a plain control or timing signal with no handshake.

Top module: `baud_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), both divisor bytes clear to 0 and the counters clear. Both outputs stay low during reset. With mode inputs all 0, the first `baud_tick` comes on the 64th clock cycle counted from the first cycle after release.
- R2: Asynchronous (`sync_mode`=0), 8-bit (`wide_div`=0), `fast_sel`=0: `baud_tick` period is 64·(n+1) clocks.
- R3: Asynchronous with exactly one of `wide_div` and `fast_sel` set: period is 16·(n+1) clocks.
- R4: Asynchronous with both `wide_div` and `fast_sel` set: period is 4·(n+1) clocks.
- R5: With `sync_mode`=1 the period is 4·(n+1) clocks for either divisor width, and `fast_sel` has no effect.
- R6: With `wide_div`=0, n is the low divisor byte alone. The high byte has no effect on the period.
- R7: With `wide_div`=1, n is {high byte, low byte}, with the high byte in bits 15:8.
- R8: A write strobe on either divisor byte at a clock edge restarts both counters. The next `baud_tick` comes P·(n+1) cycles later, counting the cycle after that edge as the first, where P is the mode's prescale. `sample_en` is low in that first cycle.
- R9: A change on any mode input restarts both counters in the same way, using the new mode's period.
- R10: `sample_en` pulses once every P clocks between restarts. Each `baud_tick` coincides with a `sample_en` pulse, and there are n+1 `sample_en` pulses per tick period.
- R11: `baud_tick` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_hi_wr | input | 1 | Load `div_wdata` into the high divisor byte |
| div_lo_wr | input | 1 | Load `div_wdata` into the low divisor byte |
| div_wdata | input | 8 | Divisor byte write data |
| wide_div | input | 1 | 1: 16-bit divisor; 0: low byte only |
| fast_sel | input | 1 | Fast-rate select (asynchronous mode only) |
| sync_mode | input | 1 | Synchronous operation; prescale fixed at 4 |
| sample_en | output | 1 | One-cycle enable, once per prescale round |
| baud_tick | output | 1 | One-cycle tick, once per baud period |

## Verification
The assertions assume that the mode inputs and strobes are sampled only at rising edges. They also assume that the checker's own copy of the previous mode reflects the same edges the design sees, which holds because both register the ports at the same edges after reset. The period assertion is suspended in any cycle that carries a write strobe or a mode change. The bench therefore changes mode and writes bytes only on falling edges and holds them for whole cycles. It measures periods only after the restart that its own write produced, so every measured window lies in a span with no restart.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int PRE_W  = 6;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    PRE_X64 = 2'd0,
    PRE_X16 = 2'd1,
    PRE_X4  = 2'd2
  } prescale_e;

  typedef struct packed {
    logic sync_mode;
    logic wide_div;
    logic fast_sel;
  } mode_t;

  function automatic prescale_e decode_mode(mode_t m);
    if (m.sync_mode)                 return PRE_X4;
    else if (m.wide_div && m.fast_sel) return PRE_X4;
    else if (m.wide_div ^ m.fast_sel)  return PRE_X16;
    else                             return PRE_X64;
  endfunction

  function automatic logic [PRE_W-1:0] prescale_term(prescale_e p);
    case (p)
      PRE_X4:  return PRE_W'(3);
      PRE_X16: return PRE_W'(15);
      default: return PRE_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/baud_mode_dec.sv
module baud_mode_dec
  import baud_pkg::*;
(
  input  mode_t            mode,
  output logic [PRE_W-1:0] pre_term
);
  prescale_e sel;

  always_comb begin
    sel      = decode_mode(mode);
    pre_term = prescale_term(sel);
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] term,
  output logic         tc
);
  logic [W-1:0] cnt;

  assign tc = (cnt == term);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (tc)           cnt <= '0;
    else                   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt;
  logic         at_limit;

  assign at_limit = (cnt == limit);
  assign wrap     = step && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (step)         cnt <= at_limit ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_hi_wr,
  input  logic              div_lo_wr,
  input  logic [BYTE_W-1:0] div_wdata,
  input  logic              wide_div,
  input  logic              fast_sel,
  input  logic              sync_mode,
  output logic              sample_en,
  output logic              baud_tick
);
  localparam int NBYTES = DIV_W / BYTE_W;

  mode_t             mode_in, mode_q;
  logic              mode_chg, restart;
  logic [NBYTES-1:0] byte_wr;
  logic [DIV_W-1:0]  div_q, div_eff;
  logic [PRE_W-1:0]  pre_term;

  assign mode_in  = '{sync_mode: sync_mode, wide_div: wide_div, fast_sel: fast_sel};
  assign mode_chg = (mode_in != mode_q);
  assign byte_wr  = {div_hi_wr, div_lo_wr};
  assign restart  = mode_chg || (|byte_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_in;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_div_byte
    always_ff @(posedge clk) begin
      if (!rst_n)          div_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (byte_wr[b]) div_q[b*BYTE_W +: BYTE_W] <= div_wdata;
    end
  end

  assign div_eff = mode_q.wide_div ? div_q : {{(DIV_W-BYTE_W){1'b0}}, div_q[BYTE_W-1:0]};

  baud_mode_dec u_dec (
    .mode     (mode_q),
    .pre_term (pre_term)
  );

  baud_prescaler #(.W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .term    (pre_term),
    .tc      (sample_en)
  );

  baud_divider #(.W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (sample_en),
    .limit   (div_eff),
    .wrap    (baud_tick)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic div_hi_wr,
  input logic div_lo_wr,
  input logic wide_div,
  input logic fast_sel,
  input logic sync_mode,
  input logic sample_en,
  input logic baud_tick
);
  logic [2:0] mode_d;
  logic [6:0] gap, exp_p;
  logic       chg, wr;

  assign wr  = div_hi_wr || div_lo_wr;
  assign chg = wr || ({sync_mode, wide_div, fast_sel} != mode_d);

  always_comb begin
    if (mode_d[2])                  exp_p = 7'd4;
    else if (mode_d[1] && mode_d[0]) exp_p = 7'd4;
    else if (mode_d[1] || mode_d[0]) exp_p = 7'd16;
    else                             exp_p = 7'd64;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_d <= '0;
      gap    <= 7'd1;
    end else begin
      mode_d <= {sync_mode, wide_div, fast_sel};
      if (chg || sample_en) gap <= 7'd1;
      else                  gap <= gap + 7'd1;
    end
  end

  assert_tick_on_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> sample_en);

  assert_enable_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !chg) |-> (gap == exp_p));

  assert_single_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  assert_write_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !sample_en);

  assert_mode_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ({sync_mode, wide_div, fast_sel} != mode_d) |=> (!sample_en && !baud_tick));
endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_hi_wr (div_hi_wr),
  .div_lo_wr (div_lo_wr),
  .wide_div  (wide_div),
  .fast_sel  (fast_sel),
  .sync_mode (sync_mode),
  .sample_en (sample_en),
  .baud_tick (baud_tick)
);

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_hi_wr = 1'b0, div_lo_wr = 1'b0;
  logic [7:0] div_wdata = '0;
  logic       wide_div = 1'b0, fast_sel = 1'b0, sync_mode = 1'b0;
  logic       sample_en, baud_tick;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .div_hi_wr(div_hi_wr), .div_lo_wr(div_lo_wr),
    .div_wdata(div_wdata), .wide_div(wide_div), .fast_sel(fast_sel),
    .sync_mode(sync_mode), .sample_en(sample_en), .baud_tick(baud_tick)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int prescale(bit w, bit f, bit s);
    if (s) return 4;
    if (w && f) return 4;
    if (w || f) return 16;
    return 64;
  endfunction

  function automatic string req_of(bit w, bit f, bit s);
    if (s) return "R5";
    if (w && f) return "R4";
    if (w || f) return "R3";
    return "R2";
  endfunction

  // Count negedge samples up to and including the next tick; also count enables.
  task automatic count_to_tick(output int cyc, output int ens, input bit clear_wr);
    cyc = 0; ens = 0;
    forever begin
      @(negedge clk);
      if (clear_wr && cyc == 0) begin div_lo_wr = 1'b0; div_hi_wr = 1'b0; end
      cyc++;
      if (sample_en) ens++;
      if (baud_tick || cyc > 300000) break;
    end
  endtask

  // Configure, restart by a low-byte write, measure first and steady periods.
  task automatic run_case(bit w, bit f, bit s, logic [7:0] hi, logic [7:0] lo,
                          int n_exp, string req);
    int cyc, ens, per;
    per = prescale(w, f, s) * (n_exp + 1);
    @(negedge clk);
    wide_div = w; fast_sel = f; sync_mode = s;
    div_hi_wr = 1'b1; div_wdata = hi;
    @(negedge clk);
    div_hi_wr = 1'b0; div_lo_wr = 1'b1; div_wdata = lo;
    count_to_tick(cyc, ens, 1'b1);
    check_eq(req, "first period after write (R8)", cyc, per);
    count_to_tick(cyc, ens, 1'b0);
    check_eq(req, "steady period", cyc, per);
    check_eq("R10", "enables per period", ens, n_exp + 1);
    @(negedge clk);
    check_eq("R11", "tick after tick", int'(baud_tick), 0);
  endtask

  initial begin : wdog
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    int cyc, ens;
    int nlist[4] = '{0, 1, 7, 255};
    // R1: reset state and first tick after release
    repeat (3) @(negedge clk);
    check_eq("R1", "tick in reset", int'(baud_tick), 0);
    check_eq("R1", "sample_en in reset", int'(sample_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 1; ens = 0;
    while (!baud_tick && cyc < 1000) begin @(negedge clk); cyc++; end
    check_eq("R1", "first tick after reset", cyc, 64);

    // R2..R5 sweep over all mode combinations and several divisors
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 4; k++) begin
        run_case(m[2], m[1], m[0], 8'h00, 8'(nlist[k]), nlist[k],
                 req_of(m[2], m[1], m[0]));
      end
    end

    // R6: high byte ignored in 8-bit mode
    run_case(1'b0, 1'b0, 1'b0, 8'hFF, 8'd3, 3, "R6");
    run_case(1'b0, 1'b1, 1'b1, 8'hA5, 8'd2, 2, "R6");
    // R7: both bytes used in 16-bit mode
    run_case(1'b1, 1'b0, 1'b0, 8'h01, 8'h00, 256, "R7");
    run_case(1'b1, 1'b1, 1'b0, 8'h0F, 8'hFF, 4095, "R7");

    // R8: mid-period write restarts the count
    run_case(1'b0, 1'b1, 1'b0, 8'h00, 8'd9, 9, "R8");
    repeat (70) @(negedge clk);
    div_lo_wr = 1'b1; div_wdata = 8'd9;
    count_to_tick(cyc, ens, 1'b1);
    check_eq("R8", "period after mid-period low write", cyc, 160);
    repeat (33) @(negedge clk);
    div_hi_wr = 1'b1; div_wdata = 8'h77;
    count_to_tick(cyc, ens, 1'b1);
    check_eq("R8", "period after mid-period high write", cyc, 160);

    // R9: mode change restarts with the new rate
    run_case(1'b0, 1'b0, 1'b0, 8'h00, 8'd9, 9, "R2");
    repeat (100) @(negedge clk);
    fast_sel = 1'b1;
    count_to_tick(cyc, ens, 1'b0);
    check_eq("R9", "period after fast_sel change", cyc, 160);
    repeat (21) @(negedge clk);
    sync_mode = 1'b1;
    count_to_tick(cyc, ens, 1'b0);
    check_eq("R9", "period after sync_mode change", cyc, 40);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule